// File: doc/BRIEF.md
# Trap and Interrupt Arbitration Controller

This block decides, cycle by cycle, which fault or interrupt a pipelined core acts on. It takes error flags from a writeback stage, the synchronous fault flags of the instruction in decode/execute and a pending-interrupt flag. It then raises either an exception strobe with its cause code or an interrupt strobe. It also flushes the pipeline for one cycle whenever it takes either. While a decision must wait, it holds decode with a stall. A parameter says whether the core has a writeback stage. The ranking of faults and the waiting rules depend on that parameter.

With a writeback stage, a load or store that errors in writeback is the oldest instruction, so its fault wins. A fault in decode/execute is only resolved once writeback holds no outstanding load/store. An interrupt that arrives while a load/store sits in decode lets that load/store move on into writeback. Decode is then stalled and the interrupt is held until writeback drains. Without a writeback stage, load/store errors belong to the execute-stage instruction and are ranked after its other faults. The interrupt then waits only for the load/store to leave decode, because the core itself stalls on it.

The controller is a four-state machine. The states are `ST_IDLE`, `ST_WAIT_WB`, `ST_IRQ_HOLD` and `ST_FLUSH`. Every state other than `ST_FLUSH` evaluates the same decision. A take (exception or interrupt) moves to `ST_FLUSH`. Otherwise, a decode fault that must wait moves to `ST_WAIT_WB`. Otherwise, a pending interrupt that cannot be taken moves to `ST_IRQ_HOLD`. Otherwise the machine goes to `ST_IDLE`. `ST_FLUSH` blanks all outputs for one cycle and always returns to `ST_IDLE`. Asynchronous reset enters `ST_IDLE`.

Top module: `trap_arbiter`

## Requirements
- R1: Reset puts the controller in its idle state. With all inputs low every output is 0, and a fault present while reset is held is taken at once, without a blanking cycle.
- R2: Among decode/execute faults the ranking is fetch error (cause 1), then illegal instruction (cause 2), then environment call (cause 11), then breakpoint (cause 3). The winner is reported on `exc_cause` together with `exc_take`.
- R3: With `WB_STAGE`=1, a decode/execute fault is not taken while `wb_lsu_busy` is 1. During that time `dx_stall` is 1. The fault is taken in the first cycle in which `wb_lsu_busy` is 0.
- R4: With `WB_STAGE`=1, a writeback load error (cause 5) or store error (cause 7) is taken ahead of any decode/execute fault, including a fetch error, and even while `wb_lsu_busy` is 1. A load error wins over a store error.
- R5: With `WB_STAGE`=0, the inputs `wb_load_err`, `wb_store_err` and `wb_lsu_busy` have no effect. The execute-stage load error (cause 5) and store error (cause 7) rank below breakpoint, with load ahead of store.
- R6: An interrupt is never taken while `dx_lsu_op` is 1, and `dx_stall` stays 0 while the load/store is in decode. With `WB_STAGE`=1, once the load/store has left decode, `dx_stall` is 1 while `wb_lsu_busy` is 1. The interrupt is taken in the first cycle with both flags low.
- R7: With `WB_STAGE`=0, a pending interrupt is taken in the first cycle in which `dx_lsu_op` is 0, whatever `wb_lsu_busy` is.
- R8: When a synchronous exception can be taken in the same cycle as a pending interrupt, the exception is taken and `irq_take` stays 0.
- R9: Every take raises `pipe_flush` in the same cycle for exactly one cycle. In the following cycle `exc_take`, `irq_take` and `dx_stall` are 0 regardless of the inputs.
- R10: With `WB_STAGE`=1, the execute-stage inputs `dx_load_err` and `dx_store_err` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wb_load_err | input | 1 | Load in writeback returned an error |
| wb_store_err | input | 1 | Store in writeback returned an error |
| wb_lsu_busy | input | 1 | A load/store is outstanding in writeback |
| dx_fetch_err | input | 1 | Decode/execute instruction had a fetch error |
| dx_illegal | input | 1 | Decode/execute instruction is illegal |
| dx_ecall | input | 1 | Decode/execute instruction is an environment call |
| dx_ebreak | input | 1 | Decode/execute instruction is a breakpoint |
| dx_load_err | input | 1 | Execute-stage load error (used without writeback) |
| dx_store_err | input | 1 | Execute-stage store error (used without writeback) |
| irq_pending | input | 1 | An enabled interrupt is pending |
| dx_lsu_op | input | 1 | A load/store instruction is in decode |
| exc_take | output | 1 | Exception taken this cycle |
| exc_cause | output | 5 | Cause code of the taken exception, 0 otherwise |
| irq_take | output | 1 | Interrupt taken this cycle |
| dx_stall | output | 1 | Hold decode while a decision waits |
| pipe_flush | output | 1 | Flush the pipeline this cycle |

## Verification
A state machine stuck in or wrongly skipping `ST_FLUSH` shows in the very next cycle. It appears either as a second take right after a flush or as a lost take after reset. Wrong ranking or gating is combinational, so it appears in the same cycle as the stimulus, as a wrong cause code, an early take or a missing stall. Both parameter variants get the same input sequence, so a gate applied to the wrong variant shows up as a divergence between the two instances within one cycle.

// File: rtl/trap_arb_pkg.sv
package trap_arb_pkg;

    localparam int CAUSE_W = 5;

    typedef logic [CAUSE_W-1:0] cause_t;

    localparam cause_t CAUSE_NONE    = cause_t'(0);
    localparam cause_t CAUSE_FETCH   = cause_t'(1);
    localparam cause_t CAUSE_ILLEGAL = cause_t'(2);
    localparam cause_t CAUSE_BREAK   = cause_t'(3);
    localparam cause_t CAUSE_LOAD    = cause_t'(5);
    localparam cause_t CAUSE_STORE   = cause_t'(7);
    localparam cause_t CAUSE_ECALL   = cause_t'(11);

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_WB  = 2'd1,
        ST_IRQ_HOLD = 2'd2,
        ST_FLUSH    = 2'd3
    } arb_state_t;

endpackage

// File: rtl/trap_arb_dx_rank.sv
// Ranks the faults of the instruction in decode/execute.
module trap_arb_dx_rank
    import trap_arb_pkg::*;
#(
    parameter bit WB_STAGE = 1'b1
) (
    input  logic   fetch_err,
    input  logic   illegal,
    input  logic   ecall,
    input  logic   ebreak,
    input  logic   load_err,
    input  logic   store_err,
    output logic   fault,
    output cause_t cause
);
    logic lsu_fault;
    logic [1:0] lsu_flags;

    generate
        if (WB_STAGE) begin : g_lsu_in_wb
            // load/store errors are reported by the writeback stage instead
            logic unused_lsu;
            assign unused_lsu = load_err | store_err;
            assign lsu_flags  = 2'b00;
        end else begin : g_lsu_in_ex
            assign lsu_flags = {load_err, store_err};
        end
    endgenerate

    assign lsu_fault = |lsu_flags;
    assign fault     = fetch_err | illegal | ecall | ebreak | lsu_fault;

    always_comb begin
        if (fetch_err)         cause = CAUSE_FETCH;
        else if (illegal)      cause = CAUSE_ILLEGAL;
        else if (ecall)        cause = CAUSE_ECALL;
        else if (ebreak)       cause = CAUSE_BREAK;
        else if (lsu_flags[1]) cause = CAUSE_LOAD;
        else if (lsu_flags[0]) cause = CAUSE_STORE;
        else                   cause = CAUSE_NONE;
    end

endmodule

// File: rtl/trap_arb_wb_rank.sv
// Ranks the faults reported from writeback and qualifies its busy flag.
module trap_arb_wb_rank
    import trap_arb_pkg::*;
#(
    parameter bit WB_STAGE = 1'b1
) (
    input  logic   load_err,
    input  logic   store_err,
    input  logic   lsu_busy,
    output logic   fault,
    output logic   busy,
    output cause_t cause
);
    generate
        if (WB_STAGE) begin : g_present
            assign fault = load_err | store_err;
            assign busy  = lsu_busy;
            assign cause = load_err  ? CAUSE_LOAD  :
                           store_err ? CAUSE_STORE : CAUSE_NONE;
        end else begin : g_absent
            logic unused_wb;
            assign unused_wb = load_err | store_err | lsu_busy;
            assign fault     = 1'b0;
            assign busy      = 1'b0;
            assign cause     = CAUSE_NONE;
        end
    endgenerate

endmodule

// File: rtl/trap_arb_irq_gate.sv
// Decides whether a pending interrupt may be taken now, or must be held
// with decode stalled behind a load/store that already left decode.
module trap_arb_irq_gate (
    input  logic irq_pending,
    input  logic lsu_in_dx,
    input  logic wb_busy,
    output logic irq_ok,
    output logic irq_hold_stall
);
    assign irq_ok         = irq_pending & ~lsu_in_dx & ~wb_busy;
    assign irq_hold_stall = irq_pending & ~lsu_in_dx &  wb_busy;
endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_arb_pkg::*;
#(
    parameter bit WB_STAGE = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wb_load_err,
    input  logic                 wb_store_err,
    input  logic                 wb_lsu_busy,
    input  logic                 dx_fetch_err,
    input  logic                 dx_illegal,
    input  logic                 dx_ecall,
    input  logic                 dx_ebreak,
    input  logic                 dx_load_err,
    input  logic                 dx_store_err,
    input  logic                 irq_pending,
    input  logic                 dx_lsu_op,
    output logic                 exc_take,
    output logic [CAUSE_W-1:0]   exc_cause,
    output logic                 irq_take,
    output logic                 dx_stall,
    output logic                 pipe_flush
);
    arb_state_t state_q, state_d;

    logic   wb_fault, wb_busy;
    cause_t wb_cause;
    logic   dx_fault;
    cause_t dx_cause;
    logic   irq_ok, irq_hold_stall;
    logic   dx_ready, dx_waiting;

    trap_arb_wb_rank #(.WB_STAGE(WB_STAGE)) u_wb_rank (
        .load_err  (wb_load_err),
        .store_err (wb_store_err),
        .lsu_busy  (wb_lsu_busy),
        .fault     (wb_fault),
        .busy      (wb_busy),
        .cause     (wb_cause)
    );

    trap_arb_dx_rank #(.WB_STAGE(WB_STAGE)) u_dx_rank (
        .fetch_err (dx_fetch_err),
        .illegal   (dx_illegal),
        .ecall     (dx_ecall),
        .ebreak    (dx_ebreak),
        .load_err  (dx_load_err),
        .store_err (dx_store_err),
        .fault     (dx_fault),
        .cause     (dx_cause)
    );

    trap_arb_irq_gate u_irq_gate (
        .irq_pending    (irq_pending),
        .lsu_in_dx      (dx_lsu_op),
        .wb_busy        (wb_busy),
        .irq_ok         (irq_ok),
        .irq_hold_stall (irq_hold_stall)
    );

    // A decode fault resolves only once writeback has drained.
    assign dx_ready   = dx_fault & ~wb_busy;
    assign dx_waiting = dx_fault &  wb_busy;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs and next state
    always_comb begin
        exc_take   = 1'b0;
        exc_cause  = CAUSE_NONE;
        irq_take   = 1'b0;
        dx_stall   = 1'b0;
        pipe_flush = 1'b0;
        state_d    = ST_IDLE;
        unique case (state_q)
            ST_FLUSH: begin
                state_d = ST_IDLE;
            end
            ST_IDLE, ST_WAIT_WB, ST_IRQ_HOLD: begin
                if (wb_fault) begin
                    exc_take   = 1'b1;
                    exc_cause  = wb_cause;
                    pipe_flush = 1'b1;
                    state_d    = ST_FLUSH;
                end else if (dx_ready) begin
                    exc_take   = 1'b1;
                    exc_cause  = dx_cause;
                    pipe_flush = 1'b1;
                    state_d    = ST_FLUSH;
                end else if (irq_ok) begin
                    irq_take   = 1'b1;
                    pipe_flush = 1'b1;
                    state_d    = ST_FLUSH;
                end else if (dx_waiting) begin
                    dx_stall   = 1'b1;
                    state_d    = ST_WAIT_WB;
                end else if (irq_pending) begin
                    dx_stall   = irq_hold_stall;
                    state_d    = ST_IRQ_HOLD;
                end else begin
                    state_d    = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // R9: flush lasts one cycle and the cycle after it is blank
    a_r9_flush_single: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_flush |=> !pipe_flush);
    a_r9_blank_after: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_flush |=> (!exc_take && !irq_take && !dx_stall));
    // R8: exception and interrupt never taken together
    a_r8_exc_over_irq: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |-> !irq_take);
    // R6: no interrupt while a load/store is in decode
    a_r6_no_irq_lsu: assert property (@(posedge clk) disable iff (!rst_n)
        dx_lsu_op |-> !irq_take);
    // R6: no stall while the load/store is still in decode with no fault
    a_r6_lsu_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (dx_lsu_op && !dx_fetch_err && !dx_illegal && !dx_ecall && !dx_ebreak) |-> !dx_stall);

    generate
        if (WB_STAGE) begin : g_chk_wb
            // R3: nothing resolves while writeback is busy without a writeback fault
            a_r3_wait_wb: assert property (@(posedge clk) disable iff (!rst_n)
                (wb_lsu_busy && !wb_load_err && !wb_store_err) |-> (!exc_take && !irq_take));
            // R4: writeback load error wins whenever the machine is not blanking
            a_r4_wb_first: assert property (@(posedge clk) disable iff (!rst_n)
                (state_q != ST_FLUSH && wb_load_err) |-> (exc_take && exc_cause == CAUSE_LOAD));
        end else begin : g_chk_nowb
            // R7: interrupt alone, outside a flush and a load/store, is taken
            a_r7_irq_now: assert property (@(posedge clk) disable iff (!rst_n)
                (state_q != ST_FLUSH && irq_pending && !dx_lsu_op && !dx_fetch_err &&
                 !dx_illegal && !dx_ecall && !dx_ebreak && !dx_load_err && !dx_store_err)
                |-> irq_take);
        end
    endgenerate

endmodule

// File: tb/trap_arbiter_test.sv
`timescale 1ns/1ps
module trap_arbiter_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    // input vector bits: {wbl, wbs, wbb, fe, il, ec, eb, xl, xs, irq, lsu}
    logic [10:0] vin = '0;
    // expected bits: {exc_take, exc_cause[4:0], irq_take, dx_stall, pipe_flush}
    logic        w_exc, w_irq, w_stall, w_flush;
    logic [4:0]  w_cause;
    logic        n_exc, n_irq, n_stall, n_flush;
    logic [4:0]  n_cause;

    trap_arbiter #(.WB_STAGE(1'b1)) uut (
        .clk(clk), .rst_n(rst_n),
        .wb_load_err(vin[10]), .wb_store_err(vin[9]), .wb_lsu_busy(vin[8]),
        .dx_fetch_err(vin[7]), .dx_illegal(vin[6]), .dx_ecall(vin[5]), .dx_ebreak(vin[4]),
        .dx_load_err(vin[3]), .dx_store_err(vin[2]),
        .irq_pending(vin[1]), .dx_lsu_op(vin[0]),
        .exc_take(w_exc), .exc_cause(w_cause), .irq_take(w_irq),
        .dx_stall(w_stall), .pipe_flush(w_flush)
    );

    trap_arbiter #(.WB_STAGE(1'b0)) uut_nowb (
        .clk(clk), .rst_n(rst_n),
        .wb_load_err(vin[10]), .wb_store_err(vin[9]), .wb_lsu_busy(vin[8]),
        .dx_fetch_err(vin[7]), .dx_illegal(vin[6]), .dx_ecall(vin[5]), .dx_ebreak(vin[4]),
        .dx_load_err(vin[3]), .dx_store_err(vin[2]),
        .irq_pending(vin[1]), .dx_lsu_op(vin[0]),
        .exc_take(n_exc), .exc_cause(n_cause), .irq_take(n_irq),
        .dx_stall(n_stall), .pipe_flush(n_flush)
    );

    typedef struct packed {
        logic [10:0] stim;
        logic [8:0]  exp_wb;
        logic [8:0]  exp_nowb;
        logic [7:0]  req;
    } vec_t;

    localparam logic [8:0] Z   = 9'b0_00000_0_0_0;
    localparam logic [8:0] STL = 9'b0_00000_0_1_0;
    localparam logic [8:0] IRQ = 9'b0_00000_1_0_1;
    localparam logic [8:0] E1  = 9'b1_00001_0_0_1;
    localparam logic [8:0] E2  = 9'b1_00010_0_0_1;
    localparam logic [8:0] E3  = 9'b1_00011_0_0_1;
    localparam logic [8:0] E5  = 9'b1_00101_0_0_1;
    localparam logic [8:0] E7  = 9'b1_00111_0_0_1;
    localparam logic [8:0] E11 = 9'b1_01011_0_0_1;

    localparam int NV = 33;
    localparam vec_t VECS [NV] = '{
        '{11'b000_0011_00_00, E11, E11, 8'd2},  // R2 ecall beats ebreak
        '{11'b000_1000_00_00, Z,   Z,   8'd9},  // R9 blank cycle ignores fetch err
        '{11'b000_1110_00_00, E1,  E1,  8'd2},  // R2 fetch first
        '{11'b000_0000_00_00, Z,   Z,   8'd9},  // R9
        '{11'b001_0100_00_00, STL, E2,  8'd3},  // R3 wait / R5 busy ignored
        '{11'b001_0100_00_00, STL, Z,   8'd3},  // R3 still waiting
        '{11'b101_0100_00_00, E5,  E2,  8'd4},  // R4 wb load wins / R5
        '{11'b000_0000_00_00, Z,   Z,   8'd9},  // R9
        '{11'b010_1000_00_00, E7,  E1,  8'd4},  // R4 wb store over fetch / R5
        '{11'b000_0000_00_00, Z,   Z,   8'd9},  // R9
        '{11'b000_0001_10_00, E3,  E3,  8'd5},  // R5 ebreak over ex load, R10
        '{11'b000_0000_00_00, Z,   Z,   8'd9},  // R9
        '{11'b000_0000_01_00, Z,   E7,  8'd10}, // R10 ignored / R5 ex store
        '{11'b000_0000_11_00, Z,   Z,   8'd10}, // R10 / R9 blank
        '{11'b000_0000_11_00, Z,   E5,  8'd5},  // R5 load over store
        '{11'b000_0000_00_00, Z,   Z,   8'd9},  // R9
        '{11'b000_0000_00_11, Z,   Z,   8'd6},  // R6 lsu in decode
        '{11'b000_0000_00_11, Z,   Z,   8'd6},  // R6
        '{11'b001_0000_00_10, STL, IRQ, 8'd6},  // R6 hold / R7 taken
        '{11'b000_0000_00_10, IRQ, Z,   8'd6},  // R6 taken after drain
        '{11'b000_0000_00_00, Z,   Z,   8'd9},  // R9
        '{11'b000_0010_00_10, E11, E11, 8'd8},  // R8 exception beats irq
        '{11'b000_0000_00_10, Z,   Z,   8'd9},  // R9 irq blanked
        '{11'b000_0000_00_10, IRQ, IRQ, 8'd7},  // R7 plain irq
        '{11'b000_0000_00_00, Z,   Z,   8'd9},  // R9
        '{11'b001_0000_00_10, STL, IRQ, 8'd7},  // R7 wb busy ignored / R6
        '{11'b101_0000_00_10, E5,  Z,   8'd4},  // R4 wb error during irq hold
        '{11'b000_0000_00_00, Z,   Z,   8'd9},  // R9
        '{11'b001_0010_00_00, STL, E11, 8'd3},  // R3 waiting on writeback
        '{11'b000_0010_00_00, E11, Z,   8'd3},  // R3 taken when drained
        '{11'b000_0000_00_00, Z,   Z,   8'd9},  // R9
        '{11'b000_0111_00_00, E2,  E2,  8'd2},  // R2 illegal over ecall/ebreak
        '{11'b000_0000_00_00, Z,   Z,   8'd9}   // R9
    };

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    task automatic check_both(input logic [8:0] ew, input logic [8:0] en, input int rq);
        logic [8:0] aw, an;
        aw = {w_exc, w_cause, w_irq, w_stall, w_flush};
        an = {n_exc, n_cause, n_irq, n_stall, n_flush};
        n_checks += 2;
        if (aw !== ew) begin
            n_fail++;
            $display("FAIL R%0d wb-variant actual=%b expected=%b", rq, aw, ew);
        end
        if (an !== en) begin
            n_fail++;
            $display("FAIL R%0d no-wb-variant actual=%b expected=%b", rq, an, en);
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        // R1: outputs quiet during and after reset
        vin = '0;
        repeat (3) @(negedge clk);
        #1 check_both(Z, Z, 1);
        @(negedge clk) rst_n = 1'b1;
        #1 check_both(Z, Z, 1);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            vin = VECS[i].stim;
            #1 check_both(VECS[i].exp_wb, VECS[i].exp_nowb, int'(VECS[i].req));
        end

        // R1: reset out of the blanking cycle makes a fault take at once
        @(negedge clk) vin = 11'b000_0010_00_00;
        #1 check_both(E11, E11, 2);
        @(negedge clk) rst_n = 1'b0;
        #1 check_both(E11, E11, 1);
        @(negedge clk) begin
            rst_n = 1'b1;
            vin   = '0;
        end
        #1 check_both(Z, Z, 1);

        // R9: back-to-back faults held high take every other cycle
        @(negedge clk) vin = 11'b000_1000_00_00;
        #1 check_both(E1, E1, 9);
        @(negedge clk);
        #1 check_both(Z, Z, 9);
        @(negedge clk);
        #1 check_both(E1, E1, 9);
        @(negedge clk) vin = '0;
        #1 check_both(Z, Z, 9);

        // R4: both writeback errors, load wins; fetch error below them
        @(negedge clk) vin = 11'b110_1000_00_00;
        #1 check_both(E5, E1, 4);
        @(negedge clk) vin = '0;
        #1 check_both(Z, Z, 9);

        @(negedge clk);
        finish_run();
    end

endmodule